// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block caches page table entries for a processor's address translation path and sits in front of the page table walker. Every lookup compares the requested virtual page number and the current context identifier against all valid entries at once. A match returns the physical page number and a rights verdict combinationally, in the same cycle as the request. A lookup that finds nothing starts a walk. The entry the walker returns is written into a free line if there is one, and otherwise into the least recently used line. The response to the original request is given in the cycle the walker answers.

Each entry carries the context identifier of the process that owns it. Translations of several processes can therefore sit side by side, and a context switch needs no flush. Software can clear the whole buffer in one cycle, or clear only the lines that belong to one context.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every entry is invalid, `req_ready` is high, `walk_req` is low and `resp_valid` is low.
- R2: An accepted request whose page number and context both match a valid entry raises `resp_valid` in the same cycle. `resp_ppn` then carries the stored physical page and `resp_pfault` is low.
- R3: A request whose page number matches but whose context differs is a miss. Entries for the same page number under different contexts coexist, and each one hits only under its own context.
- R4: An accepted miss raises `walk_req` in the next cycle, with `walk_vpn` and `walk_ctx` set to the request. These hold until `walk_done`. In the `walk_done` cycle `resp_valid` is high with the walker's page, and the entry is installed from the following edge onward.
- R5: When no line is free, a refill replaces the least recently used line. A hit and a fill each make their line the most recent.
- R6: When any line is invalid, a refill uses the lowest-numbered invalid line and evicts no valid entry.
- R7: Rights are checked on every hit and on every refill response. `req_acc` 01 is a write and needs rights bit 0. Code 10 is an instruction fetch and needs rights bit 1. Codes 00 and 11 are reads and are always allowed. A failed check raises `resp_denied`.
- R8: A walker answer with `walk_fault` high raises `resp_valid` and `resp_pfault`, holds `resp_denied` low and installs nothing.
- R9: While a refill is outstanding, `req_ready` is low and a presented request is ignored: it gives no response, starts no walk and leaves the walk address unchanged.
- R10: `flush_all` invalidates every entry in one cycle. A refill that completes in a flush cycle still answers but is not installed. `req_ready` is low in any flush cycle.
- R11: `flush_ctx` invalidates only the entries whose context equals `flush_ctx_id`. Entries of other contexts keep hitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_vpn | input | 5 | Virtual page number to translate |
| req_ctx | input | 4 | Context identifier of the requester |
| req_acc | input | 2 | Access kind: 00/11 read, 01 write, 10 fetch |
| resp_valid | output | 1 | Translation result present |
| resp_ppn | output | 3 | Physical page number |
| resp_denied | output | 1 | Rights do not allow this access kind |
| resp_pfault | output | 1 | Walker reported no valid mapping |
| walk_req | output | 1 | Refill outstanding, walker asked for an entry |
| walk_vpn | output | 5 | Page number to walk |
| walk_ctx | output | 4 | Context to walk |
| walk_done | input | 1 | Walker answer present |
| walk_ppn | input | 3 | Physical page from the walker |
| walk_rights | input | 2 | Rights from the walker: bit 0 write, bit 1 fetch |
| walk_fault | input | 1 | Walker found no valid mapping |
| flush_all | input | 1 | Invalidate every entry |
| flush_ctx | input | 1 | Invalidate entries of one context |
| flush_ctx_id | input | 4 | Context to invalidate with `flush_ctx` |

## Verification
The bench fills the buffer, touches its oldest line and forces a refill. It then checks that the second-oldest page is the one that misses; a design that ages lines wrongly or ignores hits would evict the touched page instead. It also flushes one context out of a full buffer and refills. A design that skips the free-line preference would throw out a surviving entry of another context, and that entry would then miss. Same-page lookups under different contexts catch a comparator that ignores the tag. Lookups presented during a refill or during a flush show that a design which lets them through either answers twice or loses the walk address. Faulting walks are repeated to catch a design that installs a faulting entry.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

    localparam int CTX_W = 4;
    localparam int VPN_W = 5;
    localparam int PPN_W = 3;
    localparam int RGT_W = 2;
    localparam int ACC_W = 2;

    localparam logic [ACC_W-1:0] ACC_WRITE = 2'b01;
    localparam logic [ACC_W-1:0] ACC_FETCH = 2'b10;

    typedef struct packed {
        logic             vld;
        logic [CTX_W-1:0] ctx;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        logic [RGT_W-1:0] rgt;
    } tlb_ent_t;

    // bit 0 of the rights grants writes, bit 1 grants fetches; reads always pass
    function automatic logic acc_denied(input logic [ACC_W-1:0] acc,
                                        input logic [RGT_W-1:0] rgt);
        logic deny;
        deny = 1'b0;
        if (acc == ACC_WRITE) deny = !rgt[0];
        if (acc == ACC_FETCH) deny = !rgt[1];
        return deny;
    endfunction

endpackage

// File: rtl/ctx_tlb_match.sv
module ctx_tlb_match
    import ctx_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  tlb_ent_t [ENTRIES-1:0]    ents,
    input  logic     [VPN_W-1:0]      lk_vpn,
    input  logic     [CTX_W-1:0]      lk_ctx,
    output logic                      hit,
    output logic     [IDX_W-1:0]      hit_idx,
    output tlb_ent_t                  hit_ent
);

    logic [ENTRIES-1:0] hit_vec;

    // one comparator per line: valid, page and context must all agree
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ents[g].vld
                          && (ents[g].vpn == lk_vpn)
                          && (ents[g].ctx == lk_ctx);
    end

    always_comb begin
        hit     = |hit_vec;
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
        hit_ent = ents[hit_idx];
    end

    AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R2

endmodule

// File: rtl/ctx_tlb_lru.sv
module ctx_tlb_lru #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int AGE_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] vld_vec,
    output logic [IDX_W-1:0]   victim_idx
);

    localparam logic [AGE_W-1:0] AGE_OLDEST = AGE_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0][AGE_W-1:0] age;
    } lru_st_t;

    lru_st_t            st_d, st_q;
    logic [ENTRIES-1:0] oldest_vec;
    logic [IDX_W-1:0]   lru_idx;
    logic [IDX_W-1:0]   free_idx;
    logic               any_free;

    always_comb begin
        st_d = st_q;
        // ages form a permutation: the touched line becomes 0, younger ones step up
        if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)
                    st_d.age[i] = '0;
                else if (st_q.age[i] < st_q.age[touch_idx])
                    st_d.age[i] = st_q.age[i] + 1'b1;
            end
        end

        lru_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            oldest_vec[i] = (st_q.age[i] == AGE_OLDEST);
            if (oldest_vec[i]) lru_idx = IDX_W'(i);
        end

        // a free line wins over the oldest valid one; lowest index first
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_vec[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        victim_idx = any_free ? free_idx : lru_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) st_q.age[i] <= AGE_W'(i);
        end else begin
            st_q <= st_d;
        end
    end

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oldest_vec)); // R5

    AST_TOUCH_YOUNGEST: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> (st_q.age[$past(touch_idx)] == '0)); // R5

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import ctx_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [CTX_W-1:0] req_ctx,
    input  logic [ACC_W-1:0] req_acc,
    output logic             resp_valid,
    output logic [PPN_W-1:0] resp_ppn,
    output logic             resp_denied,
    output logic             resp_pfault,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    output logic [CTX_W-1:0] walk_ctx,
    input  logic             walk_done,
    input  logic [PPN_W-1:0] walk_ppn,
    input  logic [RGT_W-1:0] walk_rights,
    input  logic             walk_fault,
    input  logic             flush_all,
    input  logic             flush_ctx,
    input  logic [CTX_W-1:0] flush_ctx_id
);

    typedef struct packed {
        tlb_ent_t [ENTRIES-1:0] ents;
        logic                   busy;
        logic [VPN_W-1:0]       h_vpn;
        logic [CTX_W-1:0]       h_ctx;
        logic [ACC_W-1:0]       h_acc;
    } tlb_st_t;

    tlb_st_t            st_d, st_q;
    logic               flush_any;
    logic               req_fire;
    logic               done_fire;
    logic               fill_fire;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    tlb_ent_t           hit_ent;
    logic [IDX_W-1:0]   victim_idx;
    logic               touch;
    logic [IDX_W-1:0]   touch_idx;
    logic [ENTRIES-1:0] vld_vec;

    ctx_tlb_match #(.ENTRIES(ENTRIES)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .ents    (st_q.ents),
        .lk_vpn  (req_vpn),
        .lk_ctx  (req_ctx),
        .hit     (hit),
        .hit_idx (hit_idx),
        .hit_ent (hit_ent)
    );

    ctx_tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch      (touch),
        .touch_idx  (touch_idx),
        .vld_vec    (vld_vec),
        .victim_idx (victim_idx)
    );

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) vld_vec[i] = st_q.ents[i].vld;

        flush_any = flush_all || flush_ctx;
        req_ready = !st_q.busy && !flush_any;
        req_fire  = req_valid && req_ready;
        done_fire = st_q.busy && walk_done;
        fill_fire = done_fire && !walk_fault && !flush_any;

        // response: refill answer or same-cycle hit, never both
        resp_valid  = 1'b0;
        resp_ppn    = '0;
        resp_denied = 1'b0;
        resp_pfault = 1'b0;
        if (done_fire) begin
            resp_valid  = 1'b1;
            resp_pfault = walk_fault;
            resp_ppn    = walk_fault ? '0 : walk_ppn;
            resp_denied = !walk_fault && acc_denied(st_q.h_acc, walk_rights);
        end else if (req_fire && hit) begin
            resp_valid  = 1'b1;
            resp_ppn    = hit_ent.ppn;
            resp_denied = acc_denied(req_acc, hit_ent.rgt);
        end

        touch     = (req_fire && hit) || fill_fire;
        touch_idx = fill_fire ? victim_idx : hit_idx;

        st_d = st_q;
        if (req_fire && !hit) begin
            st_d.busy  = 1'b1;
            st_d.h_vpn = req_vpn;
            st_d.h_ctx = req_ctx;
            st_d.h_acc = req_acc;
        end
        if (done_fire) st_d.busy = 1'b0;
        if (fill_fire) begin
            st_d.ents[victim_idx].vld = 1'b1;
            st_d.ents[victim_idx].ctx = st_q.h_ctx;
            st_d.ents[victim_idx].vpn = st_q.h_vpn;
            st_d.ents[victim_idx].ppn = walk_ppn;
            st_d.ents[victim_idx].rgt = walk_rights;
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (flush_all) st_d.ents[i].vld = 1'b0;
            if (flush_ctx && (st_q.ents[i].ctx == flush_ctx_id))
                st_d.ents[i].vld = 1'b0;
        end
    end

    assign walk_req = st_q.busy;
    assign walk_vpn = st_q.h_vpn;
    assign walk_ctx = st_q.h_ctx;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !req_ready); // R9

    AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !walk_done) |=> (walk_req && $stable(walk_vpn) && $stable(walk_ctx))); // R4

    AST_MISS_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !resp_valid) |=> walk_req); // R4

    AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (vld_vec == '0)); // R10

    AST_FAULT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && walk_done && walk_fault && !flush_all && !flush_ctx)
        |=> $stable(vld_vec)); // R8

    AST_FAULT_NOT_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        resp_pfault |-> (resp_valid && !resp_denied)); // R8

endmodule

// File: tb/ctx_tlb_tb.sv
`timescale 1ns/1ps
module ctx_tlb_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [4:0] req_vpn = '0;
    logic [3:0] req_ctx = '0;
    logic [1:0] req_acc = '0;
    logic       resp_valid;
    logic [2:0] resp_ppn;
    logic       resp_denied;
    logic       resp_pfault;
    logic       walk_req;
    logic [4:0] walk_vpn;
    logic [3:0] walk_ctx;
    logic       walk_done = 1'b0;
    logic [2:0] walk_ppn = '0;
    logic [1:0] walk_rights = '0;
    logic       walk_fault = 1'b0;
    logic       flush_all = 1'b0;
    logic       flush_ctx = 1'b0;
    logic [3:0] flush_ctx_id = '0;

    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    ctx_tlb u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_ctx(req_ctx), .req_acc(req_acc),
        .resp_valid(resp_valid), .resp_ppn(resp_ppn),
        .resp_denied(resp_denied), .resp_pfault(resp_pfault),
        .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_ctx(walk_ctx),
        .walk_done(walk_done), .walk_ppn(walk_ppn),
        .walk_rights(walk_rights), .walk_fault(walk_fault),
        .flush_all(flush_all), .flush_ctx(flush_ctx), .flush_ctx_id(flush_ctx_id)
    );

    // walker model: mapping is a fixed function of page and context
    function automatic logic [2:0] ppn_of(input logic [4:0] v, input logic [3:0] c);
        logic [5:0] s;
        s = {1'b0, v} + {2'b00, c};
        return s[2:0];
    endfunction
    function automatic logic [1:0] rgt_of(input logic [4:0] v);
        return v[1:0];
    endfunction
    function automatic logic deny_of(input logic [1:0] a, input logic [1:0] r);
        if (a == 2'b01) return !r[0];
        if (a == 2'b10) return !r[1];
        return 1'b0;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic lookup(input logic [4:0] v, input logic [3:0] c, input logic [1:0] a,
                          input logic exp_hit, input string tag);
        logic flt;
        @(negedge clk);
        req_valid = 1'b1; req_vpn = v; req_ctx = c; req_acc = a;
        #1;
        if (exp_hit) begin
            chk(resp_valid === 1'b1, {tag, " hit valid"}, int'(resp_valid), 1);
            chk(resp_ppn == ppn_of(v, c), {tag, " hit ppn"}, int'(resp_ppn), int'(ppn_of(v, c)));
            chk(resp_denied == deny_of(a, rgt_of(v)), {tag, " hit rights"},
                int'(resp_denied), int'(deny_of(a, rgt_of(v))));
        end else begin
            chk(resp_valid === 1'b0, {tag, " miss no resp"}, int'(resp_valid), 0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        if (walk_req) begin
            if (exp_hit) chk(1'b0, {tag, " unexpected walk"}, 1, 0);
            else chk(walk_vpn == v && walk_ctx == c, {tag, " walk addr"},
                     int'({walk_ctx, walk_vpn}), int'({c, v}));
            flt = (walk_vpn == 5'd31);
            walk_done = 1'b1; walk_fault = flt;
            walk_ppn = ppn_of(walk_vpn, walk_ctx); walk_rights = rgt_of(walk_vpn);
            #0.5;
            if (!exp_hit) begin
                chk(resp_valid === 1'b1, {tag, " refill resp"}, int'(resp_valid), 1);
                chk(resp_pfault == flt, {tag, " refill fault"}, int'(resp_pfault), int'(flt));
                if (!flt) begin
                    chk(resp_ppn == ppn_of(v, c), {tag, " refill ppn"}, int'(resp_ppn), int'(ppn_of(v, c)));
                    chk(resp_denied == deny_of(a, rgt_of(v)), {tag, " refill rights"},
                        int'(resp_denied), int'(deny_of(a, rgt_of(v))));
                end else begin
                    chk(resp_denied == 1'b0, {tag, " fault not denied"}, int'(resp_denied), 0);
                end
            end
            @(negedge clk);
            walk_done = 1'b0; walk_fault = 1'b0;
        end else if (!exp_hit) begin
            chk(1'b0, {tag, " walk_req missing"}, 0, 1);
        end
    endtask

    task automatic do_flush(input logic all, input logic [3:0] id);
        @(negedge clk);
        flush_all = all; flush_ctx = !all; flush_ctx_id = id;
        @(negedge clk);
        flush_all = 1'b0; flush_ctx = 1'b0;
    endtask

    // {vpn, ctx, acc, expected hit}; acc 00 read, 01 write, 10 fetch
    localparam logic [11:0] VEC [10] = '{
        {5'd3,  4'd1, 2'b00, 1'b0},   // cold miss
        {5'd3,  4'd1, 2'b00, 1'b1},   // hit
        {5'd3,  4'd2, 2'b00, 1'b0},   // R3 same page, other context
        {5'd3,  4'd1, 2'b01, 1'b1},   // R7 write allowed (rights 11)
        {5'd4,  4'd1, 2'b01, 1'b0},   // R7 write denied on refill (rights 00)
        {5'd4,  4'd1, 2'b10, 1'b1},   // R7 fetch denied on hit
        {5'd31, 4'd1, 2'b00, 1'b0},   // R8 walker fault
        {5'd31, 4'd1, 2'b00, 1'b0},   // R8 fault was not installed
        {5'd3,  4'd2, 2'b10, 1'b1},   // R3 both contexts resident
        {5'd5,  4'd1, 2'b10, 1'b0}    // R7 fetch denied (rights 01)
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(walk_req === 1'b0, "R1 no walk after reset", int'(walk_req), 0);
        chk(resp_valid === 1'b0, "R1 no resp after reset", int'(resp_valid), 0);

        for (int k = 0; k < 10; k++) begin
            lookup(VEC[k][11:7], VEC[k][6:3], VEC[k][2:1], VEC[k][0],
                   VEC[k][0] ? "R2 table" : "R4 table");
        end

        // R5: fill, touch the oldest, the next oldest is the victim
        do_flush(1'b1, 4'd0);
        for (int v = 0; v < 8; v++) lookup(5'(v), 4'd1, 2'b00, 1'b0, "R5 fill");
        lookup(5'd0, 4'd1, 2'b00, 1'b1, "R5 touch oldest");
        lookup(5'd10, 4'd1, 2'b00, 1'b0, "R5 refill full");
        lookup(5'd10, 4'd1, 2'b00, 1'b1, "R5 new line");
        lookup(5'd0, 4'd1, 2'b00, 1'b1, "R5 touched kept");
        lookup(5'd1, 4'd1, 2'b00, 1'b0, "R5 lru evicted");
        lookup(5'd3, 4'd1, 2'b00, 1'b1, "R5 single victim");

        // R6 / R11: flush one context of a full buffer, refills use freed lines
        do_flush(1'b1, 4'd0);
        for (int v = 0; v < 6; v++) lookup(5'(v), 4'd1, 2'b00, 1'b0, "R6 fill");
        lookup(5'd0, 4'd2, 2'b00, 1'b0, "R6 fill ctx2");
        lookup(5'd1, 4'd2, 2'b00, 1'b0, "R6 fill ctx2");
        lookup(5'd0, 4'd2, 2'b00, 1'b1, "R3 ctx2 hit");
        do_flush(1'b0, 4'd2);
        lookup(5'd0, 4'd2, 2'b00, 1'b0, "R11 ctx flushed");
        lookup(5'd0, 4'd1, 2'b00, 1'b1, "R11 R6 other ctx kept");
        lookup(5'd1, 4'd2, 2'b00, 1'b0, "R11 ctx flushed");
        lookup(5'd1, 4'd1, 2'b00, 1'b1, "R6 free line preferred");

        do_flush(1'b1, 4'd0);
        lookup(5'd1, 4'd1, 2'b00, 1'b0, "R10 flush_all");
        lookup(5'd0, 4'd2, 2'b00, 1'b0, "R10 flush_all");

        // R9: request during an outstanding refill is ignored
        @(negedge clk);
        req_valid = 1'b1; req_vpn = 5'd12; req_ctx = 4'd3; req_acc = 2'b00;
        @(negedge clk);
        req_vpn = 5'd13;
        #1;
        chk(req_ready === 1'b0, "R9 ready low busy", int'(req_ready), 0);
        chk(resp_valid === 1'b0, "R9 no resp busy", int'(resp_valid), 0);
        @(negedge clk);
        #1;
        chk(walk_vpn == 5'd12, "R9 walk addr kept", int'(walk_vpn), 12);
        req_valid = 1'b0;
        walk_done = 1'b1; walk_ppn = ppn_of(5'd12, 4'd3); walk_rights = rgt_of(5'd12);
        #0.5;
        chk(resp_ppn == ppn_of(5'd12, 4'd3), "R4 refill ppn", int'(resp_ppn), int'(ppn_of(5'd12, 4'd3)));
        @(negedge clk);
        walk_done = 1'b0;
        lookup(5'd13, 4'd3, 2'b00, 1'b0, "R9 ignored req not installed");
        lookup(5'd12, 4'd3, 2'b00, 1'b1, "R4 installed");

        // R10: request during a flush is not accepted
        @(negedge clk);
        flush_ctx = 1'b1; flush_ctx_id = 4'd3;
        req_valid = 1'b1; req_vpn = 5'd12; req_ctx = 4'd3;
        #1;
        chk(req_ready === 1'b0, "R10 ready low flush", int'(req_ready), 0);
        chk(resp_valid === 1'b0, "R10 no resp flush", int'(resp_valid), 0);
        @(negedge clk);
        flush_ctx = 1'b0; req_valid = 1'b0;
        #1;
        chk(walk_req === 1'b0, "R10 no walk from flush cycle", int'(walk_req), 0);
        lookup(5'd12, 4'd3, 2'b00, 1'b0, "R11 flushed by ctx");

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule